// File: doc/BRIEF.md
# Dual-Mode Asynchronous Host Register Port

This block lets an external processor configure a four-channel line interface over an 8-bit parallel bus that runs with no clock of its own. A strap input chooses one of two bus styles. In the first, separate active-low read and write strobes mark the cycle and an active-high address latch pulse captures the address. In the second, one active-low data strobe marks the cycle, a direction line picks read or write, and an active-low address strobe captures the address. In both styles every cycle ends with an active-low ready/acknowledge output. The host waits for it before it samples read data or releases a write.

All bus controls pass through two-flop synchronisers into the internal clock. A small handshake machine detects a cycle, waits a fixed number of clocks, then acknowledges. The register file is banked by channel: each channel owns sixteen consecutive locations starting at 16 times its number. The last location of each bank is a read-only status byte taken from an input. A few global registers sit from 0x40 upward, and every other location reads as zero. All writable storage is presented on a flat configuration output for the line-interface logic.

Top module: `host_regport`

## Requirements
- R1: While reset is low at a clock edge, all stored registers go to 0x00, ack_n goes high and hd_oe goes low.
- R2: With bus_mode = 0, a cycle runs while cs_n is low and either strb_a_n (read strobe) or ctl_b (write strobe) is low. A write stores hd_i at the latched address, and a later read returns that byte on hd_o.
- R3: With bus_mode = 1, a cycle runs while cs_n and strb_a_n (data strobe) are both low. ctl_b = 1 makes it a read and ctl_b = 0 a write, with the same storage behaviour as R2.
- R4: ack_n goes low no earlier than ACK_DLY clocks after a cycle starts. It stays low while the strobe is held, and goes high again within a few clocks after the strobe or chip select is released.
- R5: hd_oe is high only while chip select and a read are active. It is never high during a write cycle, and it is high, with valid hd_o, when ack_n goes low on a read.
- R6: The address is taken from addr_i while the address strobe is active: alat high in mode 0, alat low in mode 1. Changing addr_i after the strobe has ended does not change which register the next cycle accesses.
- R7: Register k of channel c sits at address 16*c + k, for k from 0 to 14. Its value appears on cfg_q bits [8*a+7 : 8*a], where a is the address.
- R8: The global registers at addresses 0x40 to 0x43 are read/write, and they appear on cfg_q in the same way.
- R9: Addresses from 0x44 to 0xFF read as 0x00, and a write to them changes no part of cfg_q.
- R10: Offset 15 of each channel bank reads stat_i[8*c+7 : 8*c]. A write to it is ignored, and its cfg_q slot stays 0x00.
- R11: Strobes asserted while cs_n is high start no cycle: ack_n stays high, hd_oe stays low and cfg_q does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | Strap: 0 = separate read/write strobes, 1 = data strobe plus direction |
| cs_n | input | 1 | Chip select, active low |
| alat | input | 1 | Address latch: active high in mode 0, active low in mode 1 |
| strb_a_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| ctl_b | input | 1 | Write strobe, active low (mode 0), or direction, 1 = read (mode 1) |
| addr_i | input | 8 | Address bus |
| hd_i | input | 8 | Write data from the host |
| hd_o | output | 8 | Read data to the host |
| hd_oe | output | 1 | Drive enable for the data bus |
| ack_n | output | 1 | Ready/acknowledge, active low |
| stat_i | input | 32 | Per-channel status bytes, channel c at bits [8c+7:8c] |
| cfg_q | output | 544 | All implemented locations, address a at bits [8a+7:8a] |

## Verification
The same table of writes and reads is run once in each bus style. A style whose decode is wrong then shows up as missing or misplaced data. The addresses in the table sit in different channel banks, at offsets zero and near the top, in the global area, on a status slot and just past the last global. This tells apart a wrong bank stride, a missing read-only guard and a bad bound on the implemented range. Directed cycles move the address bus after the latch strobe, hold the strobe long past the acknowledge, and drive strobes with chip select inactive. These separate address capture from live decoding, and a held handshake from one that ends on its own.

// File: rtl/hrp_pkg.sv
// Shared types and bus-style decode helpers for the host register port.
// Assumes all inputs to the helpers are already synchronised.
package hrp_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_t;

    // Read request for either bus style (mode 1: strobe low and direction high).
    function automatic logic rd_req_f(input logic mode, input logic a_n, input logic b);
        return mode ? (!a_n && b) : !a_n;
    endfunction

    // Write request for either bus style (mode 0: separate low-active write strobe).
    function automatic logic wr_req_f(input logic mode, input logic a_n, input logic b);
        return mode ? (!a_n && !b) : !b;
    endfunction

endpackage

// File: rtl/hrp_sync.sv
// Multi-bit two-flop synchroniser. Each bit is an independent level; no
// coherency between bits is assumed. RST_VAL is the inactive level per bit.
module hrp_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two-stage capture of the asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;

endmodule

// File: rtl/hrp_handshake.sv
// Cycle handshake machine. Detects a synchronised access request, waits
// ACK_DLY clocks, then holds the acknowledge until the request is removed.
// Assumes ACK_DLY >= 1 and request inputs come from synchronisers.
module hrp_handshake
    import hrp_pkg::*;
#(
    parameter int ACK_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic rd_req,
    input  logic wr_req,
    output logic ack_n,
    output logic idle,
    output logic cap_en,
    output logic wr_en
);

    localparam int CW = (ACK_DLY < 2) ? 1 : $clog2(ACK_DLY);

    hs_state_t    state;
    logic [CW-1:0] cnt;
    logic          is_wr;
    logic          live;
    logic          last_wait;

    assign live      = cs_act && (rd_req || wr_req);
    assign last_wait = (cnt == CW'(ACK_DLY - 1));

    // State, delay counter and direction of the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HS_IDLE;
            cnt   <= '0;
            is_wr <= 1'b0;
        end else begin
            case (state)
                HS_IDLE: begin
                    if (live) begin
                        state <= HS_WAIT;
                        cnt   <= '0;
                        is_wr <= wr_req;
                    end
                end
                HS_WAIT: begin
                    if (!live) begin
                        state <= HS_IDLE;
                    end else if (last_wait) begin
                        state <= HS_ACK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                HS_ACK: begin
                    if (!live) state <= HS_IDLE;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // Decoded strobes towards the register file.
    always_comb begin
        cap_en = (state == HS_IDLE) && live && rd_req;
        wr_en  = (state == HS_WAIT) && live && is_wr && last_wait;
    end

    assign ack_n = (state != HS_ACK);
    assign idle  = (state == HS_IDLE);

endmodule

// File: rtl/hrp_regfile.sv
// Channel-banked register file. Channel c occupies RPC locations from c*RPC;
// the top location of each bank is a read-only status byte. NGLB global
// registers start at GLB_BASE. Everything else reads zero and ignores writes.
module hrp_regfile #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int NCH      = 4,
    parameter int RPC      = 16,
    parameter int NGLB     = 4,
    parameter int GLB_BASE = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  cap_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NCH*DW-1:0]     stat_i,
    output logic [DW-1:0]         rd_q,
    output logic [(GLB_BASE+NGLB)*DW-1:0] cfg_q
);

    localparam int NIMP  = GLB_BASE + NGLB;
    localparam int CHTOP = NCH * RPC;

    logic [DW-1:0] slot_rd [NIMP];
    logic [DW-1:0] rsel;

    for (genvar i = 0; i < NIMP; i++) begin : g_slot
        if (i < CHTOP && (i % RPC) == RPC - 1) begin : g_stat
            assign slot_rd[i]        = stat_i[(i / RPC) * DW +: DW];
            assign cfg_q[i*DW +: DW] = '0;
        end else if (i < CHTOP || i >= GLB_BASE) begin : g_reg
            logic [DW-1:0] q;
            // Storage byte, written only on its own address.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && addr == AW'(i)) begin
                    q <= wdata;
                end
            end
            assign slot_rd[i]        = q;
            assign cfg_q[i*DW +: DW] = q;
        end else begin : g_gap
            assign slot_rd[i]        = '0;
            assign cfg_q[i*DW +: DW] = '0;
        end
    end

    // Read mux; unmatched addresses yield zero.
    always_comb begin
        rsel = '0;
        for (int i = 0; i < NIMP; i++) begin
            if (addr == AW'(i)) rsel = slot_rd[i];
        end
    end

    // Read data holding register, loaded when a read cycle is detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (cap_en) begin
            rd_q <= rsel;
        end
    end

endmodule

// File: rtl/host_regport.sv
// Dual-style asynchronous host register port. Synchronises the bus controls,
// latches the address while the address strobe is active and the handshake is
// idle, decodes the bus style and drives the register file.
// Assumes addr_i is stable for at least three clocks after the address strobe
// ends, and hd_i is stable for the whole write strobe.
module host_regport
    import hrp_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int NCH      = 4,
    parameter int RPC      = 16,
    parameter int NGLB     = 4,
    parameter int GLB_BASE = 64,
    parameter int ACK_DLY  = 3,
    localparam int NIMP    = GLB_BASE + NGLB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_mode,
    input  logic                 cs_n,
    input  logic                 alat,
    input  logic                 strb_a_n,
    input  logic                 ctl_b,
    input  logic [AW-1:0]        addr_i,
    input  logic [DW-1:0]        hd_i,
    output logic [DW-1:0]        hd_o,
    output logic                 hd_oe,
    output logic                 ack_n,
    input  logic [NCH*DW-1:0]    stat_i,
    output logic [NIMP*DW-1:0]   cfg_q
);

    logic [3:0]    ctl_s;
    logic          cs_act;
    logic          rd_req;
    logic          wr_req;
    logic          astb_act;
    logic          hs_idle;
    logic          cap_en;
    logic          wr_en;
    logic [AW-1:0] addr_q;

    hrp_sync #(
        .W       (4),
        .RST_VAL (4'b0111)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({alat, ctl_b, strb_a_n, cs_n}),
        .q_sync  (ctl_s)
    );

    // Bus-style decode of the synchronised controls.
    always_comb begin
        cs_act   = !ctl_s[0];
        rd_req   = rd_req_f(bus_mode, ctl_s[1], ctl_s[2]);
        wr_req   = wr_req_f(bus_mode, ctl_s[1], ctl_s[2]);
        astb_act = bus_mode ? !ctl_s[3] : ctl_s[3];
    end

    // Address capture while the strobe is active and no cycle is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (astb_act && hs_idle) begin
            addr_q <= addr_i;
        end
    end

    hrp_handshake #(
        .ACK_DLY (ACK_DLY)
    ) u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_act (cs_act),
        .rd_req (rd_req),
        .wr_req (wr_req),
        .ack_n  (ack_n),
        .idle   (hs_idle),
        .cap_en (cap_en),
        .wr_en  (wr_en)
    );

    hrp_regfile #(
        .AW       (AW),
        .DW       (DW),
        .NCH      (NCH),
        .RPC      (RPC),
        .NGLB     (NGLB),
        .GLB_BASE (GLB_BASE)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .cap_en (cap_en),
        .addr   (addr_q),
        .wdata  (hd_i),
        .stat_i (stat_i),
        .rd_q   (hd_o),
        .cfg_q  (cfg_q)
    );

    assign hd_oe = cs_act && rd_req;

endmodule

// File: rtl/hrp_checker.sv
// Port-level protocol checks for host_regport, attached with bind.
module hrp_checker #(
    parameter int ACK_DLY = 3,
    parameter int CFGW    = 544
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_mode,
    input logic            cs_n,
    input logic            strb_a_n,
    input logic            ctl_b,
    input logic            ack_n,
    input logic            hd_oe,
    input logic [CFGW-1:0] cfg_q
);

    logic       raw_act;
    logic       raw_rd;
    logic [7:0] act_cnt;

    assign raw_act = !cs_n && (bus_mode ? !strb_a_n : (!strb_a_n || !ctl_b));
    assign raw_rd  = bus_mode ? (!strb_a_n && ctl_b) : !strb_a_n;

    // Counts consecutive clocks of an active raw cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt <= '0;
        end else if (!raw_act) begin
            act_cnt <= '0;
        end else if (act_cnt != 8'hFF) begin
            act_cnt <= act_cnt + 8'd1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (ack_n && !hd_oe));

    // R4
    ack_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> (act_cnt >= 8'(ACK_DLY + 2)));

    // R4
    ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(raw_act)) |=> !ack_n);

    // R5
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hd_oe |-> ($past(!cs_n, 2) && $past(raw_rd, 2)));

    // R11
    no_cs_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> ack_n);

    // R9
    cfg_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ack_n) |-> $stable(cfg_q));

endmodule

bind host_regport hrp_checker #(
    .ACK_DLY (ACK_DLY),
    .CFGW    (NIMP * DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_mode (bus_mode),
    .cs_n     (cs_n),
    .strb_a_n (strb_a_n),
    .ctl_b    (ctl_b),
    .ack_n    (ack_n),
    .hd_oe    (hd_oe),
    .cfg_q    (cfg_q)
);

// File: tb/host_regport_test.sv
module host_regport_test;

    localparam int ACK_DLY = 3;
    localparam int NIMP    = 68;

    typedef struct packed {
        bit        wr;
        bit [7:0]  adr;
        bit [7:0]  dat;
        bit [15:0] tag;
    } vec_t;

    // Writes carry the data to store; reads carry the expected byte.
    localparam vec_t VEC [17] = '{
        '{1'b1, 8'h00, 8'hA5, "R7"},
        '{1'b1, 8'h13, 8'h3C, "R7"},
        '{1'b1, 8'h2E, 8'h81, "R7"},
        '{1'b1, 8'h3A, 8'hFF, "R7"},
        '{1'b1, 8'h41, 8'h5A, "R8"},
        '{1'b1, 8'h43, 8'hC3, "R8"},
        '{1'b1, 8'h44, 8'h77, "R9"},
        '{1'b1, 8'h1F, 8'h99, "R10"},
        '{1'b0, 8'h00, 8'hA5, "R7"},
        '{1'b0, 8'h13, 8'h3C, "R7"},
        '{1'b0, 8'h2E, 8'h81, "R7"},
        '{1'b0, 8'h3A, 8'hFF, "R7"},
        '{1'b0, 8'h41, 8'h5A, "R8"},
        '{1'b0, 8'h43, 8'hC3, "R8"},
        '{1'b0, 8'h44, 8'h00, "R9"},
        '{1'b0, 8'h1F, 8'hE1, "R10"},
        '{1'b0, 8'hFF, 8'h00, "R9"}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_mode = 1'b0;
    logic              cs_n = 1'b1;
    logic              alat = 1'b0;
    logic              strb_a_n = 1'b1;
    logic              ctl_b = 1'b1;
    logic [7:0]        addr_i = '0;
    logic [7:0]        hd_i = '0;
    logic [7:0]        hd_o;
    logic              hd_oe;
    logic              ack_n;
    logic [31:0]       stat_i = 32'hE3E2E1E0;
    logic [NIMP*8-1:0] cfg_q;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [7:0] mdl [NIMP];

    always #10 clk = ~clk;

    host_regport #(.ACK_DLY(ACK_DLY)) uut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
        .alat(alat), .strb_a_n(strb_a_n), .ctl_b(ctl_b), .addr_i(addr_i),
        .hd_i(hd_i), .hd_o(hd_o), .hd_oe(hd_oe), .ack_n(ack_n),
        .stat_i(stat_i), .cfg_q(cfg_q)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every cfg_q slot with the bench model.
    task automatic chk_cfg(input string tag);
        int mism = 0;
        for (int i = 0; i < NIMP; i++) begin
            if (cfg_q[i*8 +: 8] != mdl[i]) mism++;
        end
        chk(tag, "cfg_q mismatching slots", mism, 0);
    endtask

    function automatic bit writable(input logic [7:0] a);
        if (a < 8'h40) return (a[3:0] != 4'hF);
        return (a < 8'h44);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cs_n = 1'b1; strb_a_n = 1'b1; ctl_b = 1'b1;
        alat = bus_mode ? 1'b1 : 1'b0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < NIMP; i++) mdl[i] = 8'h00;
        chk("R1", "ack_n in reset", int'(ack_n), 1);
        chk("R1", "hd_oe in reset", int'(hd_oe), 0);
        chk_cfg("R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic latch_addr(input logic [7:0] a);
        addr_i = a;
        alat = bus_mode ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        if (!bus_mode) begin
            alat = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    // One bus cycle; address must already be latched.
    task automatic cycle(input bit wr, input logic [7:0] wd, input string tag,
                         output logic [7:0] rd);
        int lat = 0;
        int rel = 0;
        hd_i = wd;
        cs_n = 1'b0;
        if (bus_mode) begin
            ctl_b = wr ? 1'b0 : 1'b1;
            strb_a_n = 1'b0;
        end else if (wr) begin
            ctl_b = 1'b0;
        end else begin
            strb_a_n = 1'b0;
        end
        while (ack_n && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R4", "ack seen", int'(ack_n), 0);
        chk("R4", "ack not early", int'(lat >= ACK_DLY + 1), 1);
        chk("R5", "hd_oe at ack", int'(hd_oe), wr ? 0 : 1);
        rd = hd_o;
        repeat (5) @(negedge clk);
        chk("R4", "ack held with strobe", int'(ack_n), 0);
        cs_n = 1'b1; strb_a_n = 1'b1; ctl_b = 1'b1;
        if (bus_mode) alat = 1'b1;
        while (!ack_n && rel < 40) begin
            @(negedge clk);
            rel++;
        end
        chk("R4", "ack release latency ok", int'(rel <= 6), 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic walk(input string stag);
        logic [7:0] rd;
        for (int k = 0; k < 17; k++) begin
            string t;
            t = $sformatf("%s/%s", stag, VEC[k].tag);
            latch_addr(VEC[k].adr);
            cycle(VEC[k].wr, VEC[k].dat, t, rd);
            if (VEC[k].wr) begin
                if (writable(VEC[k].adr)) mdl[VEC[k].adr] = VEC[k].dat;
                chk_cfg(t);
            end else begin
                chk(t, $sformatf("read %0h", VEC[k].adr), int'(rd), int'(VEC[k].dat));
            end
        end
    endtask

    initial begin
        logic [7:0] rd;
        bit ack_seen;
        bit oe_seen;

        // Style with separate strobes (R2).
        bus_mode = 1'b0;
        do_reset();
        walk("R2");

        // R6: address bus moves after the latch strobe ends.
        latch_addr(8'h13);
        addr_i = 8'h00;
        repeat (2) @(negedge clk);
        cycle(1'b0, 8'h00, "R6", rd);
        chk("R6", "read after address bus change", int'(rd), 8'h3C);

        // R11: strobes without chip select.
        latch_addr(8'h00);
        ack_seen = 1'b0; oe_seen = 1'b0;
        strb_a_n = 1'b0;
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            if (!ack_n) ack_seen = 1'b1;
            if (hd_oe) oe_seen = 1'b1;
        end
        strb_a_n = 1'b1;
        hd_i = 8'h11; ctl_b = 1'b0;
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            if (!ack_n) ack_seen = 1'b1;
        end
        ctl_b = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11", "ack without cs", int'(ack_seen), 0);
        chk("R11", "hd_oe without cs", int'(oe_seen), 0);
        chk_cfg("R11");

        // Reset after writes clears storage (R1), then data-strobe style (R3).
        bus_mode = 1'b1;
        do_reset();
        walk("R3");

        // R6 in data-strobe style, R10 status of channel 3.
        latch_addr(8'h3F);
        alat = 1'b1;
        repeat (4) @(negedge clk);
        addr_i = 8'h41;
        repeat (2) @(negedge clk);
        cycle(1'b0, 8'h00, "R6", rd);
        chk("R10", "status of channel 3", int'(rd), 8'hE3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule